// File: doc/BRIEF.md
# Oversampled Serial Receive Bit Recovery

This block sits between a raw serial receive pin and a character assembler. With a receive clock at sixteen times the bit rate it removes short glitches from the line and checks that a falling edge is a real start bit, not noise. It then gives a one-cycle strobe with the recovered bit value near the middle of each bit cell.

The bit-phase counter is not tied to the start bit alone. Every filtered data edge puts it back to zero. After such a restart a short blanking interval follows, in which line activity is not examined. Because of this the block follows a sender whose clock drifts, and it keeps lock through a long run of data that has frequent edges even with no framing bits. Framing, parity and word length belong to the logic downstream. That logic sends a one-cycle `rearm` pulse once a character is complete, and the detector goes back to hunting for the next start bit. A mode input can also pick a plain one-sample-per-clock path with no filtering or validation.

Top module: `rsync_detector`

## Requirements
- R1: The filtered line level changes only after the raw line has shown the new level on 3 consecutive rising clock edges. A pulse of 1 or 2 clocks changes nothing at the outputs.
- R2: In 16x mode a filtered high-to-low change starts a start-bit check. If the check passes, `startDet` is high for exactly one cycle, 10 clocks after the edge that first sampled the low level. The filtered level is low while `startDet` is high.
- R3: If the filtered level rises while the start-bit check is still running, the detector returns to hunting with no `startDet` and no strobes. With the defaults, a low level held for 8 clocks is rejected and one held for 9 clocks is accepted.
- R4: In 16x mode no sample strobe is produced while the detector is hunting or checking a start bit.
- R5: After a start is accepted, `sampleStrobe` pulses once every 16 clocks when the line does not change. The first pulse comes 16 clocks after `startDet`, and `sampleBit` carries the filtered level during the pulse.
- R6: While bits are being sampled, each filtered line change forces the bit phase to zero. The next strobe then comes 8 clocks after that change, which is 10 clocks after the first sample of the new level.
- R7: For the 4 clocks that follow a phase restart, raw line activity is not counted toward a filtered change, so a level change inside that interval takes effect 4 clocks later than it otherwise would.
- R8: With `mode16` low, `sampleStrobe` is high on every cycle after the first, `sampleBit` equals the line sampled on the previous edge, and `startDet` stays low.
- R9: A synchronous `rst`, or a `rearm` pulse, returns the detector to hunting. After reset the filtered level is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (16x bit rate in 16x mode) |
| rst | input | 1 | Synchronous reset, active high |
| rxLine | input | 1 | Raw serial receive line, idle high |
| mode16 | input | 1 | 1 = oversampled mode with filtering and start check, 0 = one sample per clock |
| rearm | input | 1 | One-cycle request to return to start-bit hunting |
| sampleStrobe | output | 1 | One-cycle pulse marking a recovered bit |
| sampleBit | output | 1 | Recovered bit value, valid with `sampleStrobe` |
| startDet | output | 1 | One-cycle pulse when a start bit is accepted |

## Verification
The in-line properties check the parts of this block that are local in time on every cycle. These are the three-sample stability rule on the filtered level, the single-cycle width of the start and sample pulses, the low level at start acceptance, the quiet filter after a phase restart, the direct path in 1x mode, and idle outputs after reset. The exact strobe positions need whole line waveforms, so only the bench scenarios can show them. These cover placement relative to a start edge, the shift caused by a late or early data edge, the eight-versus-nine clock start boundary, the delay added by blanking, and recovery of whole characters.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic filtEnable;  // count raw line activity toward a filtered change
    logic sample16;    // oversampled-mode bit strobe
  } ctrlStrobes_t;

endpackage

// File: rtl/rsync_datapath.sv
module rsync_datapath
  import rsync_pkg::*;
#(
  parameter int STABLE_EDGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rxLine,
  input  logic         mode16,
  input  ctrlStrobes_t ctrl,
  output logic         flip,
  output logic         filtLevel,
  output logic         sampleStrobe,
  output logic         sampleBit
);

  localparam int CNT_W = $clog2(STABLE_EDGES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STABLE_EDGES - 1);

  logic [CNT_W-1:0] stableCnt;
  logic             oneXBit;
  logic             oneXValid;
  logic             differ;

  assign differ = rxLine != filtLevel;
  assign flip   = ctrl.filtEnable && differ && (stableCnt == LAST_CNT);

  // Glitch filter: the new level must persist for STABLE_EDGES samples
  always_ff @(posedge clk) begin
    if (rst) begin
      stableCnt <= '0;
      filtLevel <= 1'b1;
    end else if (!ctrl.filtEnable || !differ) begin
      stableCnt <= '0;
    end else if (flip) begin
      filtLevel <= rxLine;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // Direct path for 1x mode
  always_ff @(posedge clk) begin
    if (rst) begin
      oneXBit   <= 1'b1;
      oneXValid <= 1'b0;
    end else begin
      oneXBit   <= rxLine;
      oneXValid <= !mode16;
    end
  end

  assign sampleStrobe = mode16 ? ctrl.sample16 : oneXValid;
  assign sampleBit    = mode16 ? filtLevel : oneXBit;

  // R1: a filtered change needs three samples of the new level
  p_filter_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (filtLevel != $past(filtLevel)) |->
      ($past(rxLine) == filtLevel && $past(rxLine, 2) == filtLevel &&
       $past(rxLine, 3) == filtLevel));

  // R8: 1x mode passes the previous line sample on every cycle
  p_onex_path_r8: assert property (@(posedge clk) disable iff (rst)
    (!mode16 && !$past(mode16) && !$past(rst)) |->
      (sampleStrobe && sampleBit == $past(rxLine)));

endmodule

// File: rtl/rsync_control.sv
module rsync_control
  import rsync_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode16,
  input  logic         rearm,
  input  logic         flip,
  input  logic         filtLevel,
  output ctrlStrobes_t ctrl,
  output logic         startDet
);

  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] START_PH  = PH_W'(OVERSAMPLE / 2);
  localparam logic [PH_W-1:0] SAMPLE_PH = PH_W'(OVERSAMPLE / 2);
  localparam logic [PH_W-1:0] BLANK_PH  = PH_W'(OVERSAMPLE / 4 - 1);
  localparam logic [PH_W-1:0] WRAP_PH   = PH_W'(OVERSAMPLE - 1);

  rxState_t        state;
  logic [PH_W-1:0] phase;
  logic            blank;
  logic            resync;
  logic [PH_W-1:0] phaseNext;

  assign phaseNext = (phase == WRAP_PH) ? '0 : phase + 1'b1;
  assign resync    = (state == ST_DATA) && flip && !blank;

  assign ctrl.filtEnable = !((state == ST_DATA) && blank);
  assign ctrl.sample16   = (state == ST_DATA) && (phase == SAMPLE_PH);
  assign startDet        = (state == ST_START) && (phase == START_PH);

  always_ff @(posedge clk) begin
    if (rst || !mode16) begin
      state <= ST_HUNT;
      phase <= '0;
      blank <= 1'b0;
    end else if (rearm) begin
      state <= ST_HUNT;
      phase <= '0;
      blank <= 1'b0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (flip && filtLevel) begin
            state <= ST_START;
            phase <= '0;
          end
        end
        ST_START: begin
          if (phase == START_PH) begin
            state <= ST_DATA;
            phase <= phaseNext;
          end else if (flip) begin
            state <= ST_HUNT;
            phase <= '0;
          end else begin
            phase <= phaseNext;
          end
        end
        ST_DATA: begin
          if (resync) begin
            phase <= '0;
            blank <= 1'b1;
          end else begin
            phase <= phaseNext;
            if (blank && phase == BLANK_PH) blank <= 1'b0;
          end
        end
        default: begin
          state <= ST_HUNT;
          phase <= '0;
          blank <= 1'b0;
        end
      endcase
    end
  end

  // R2: a start is accepted only while the filtered line is low, for one cycle
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    startDet |-> (!filtLevel ##1 !startDet));

  // R3: a rise during the start check aborts it
  p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && flip && phase != START_PH) |=>
      (state == ST_HUNT && !startDet));

  // R5: bit strobes are single-cycle pulses
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.sample16 |=> !ctrl.sample16);

  // R7: the filter stays quiet right after a phase restart
  p_blank_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    resync |=> (!flip ##1 !flip ##1 !flip));

endmodule

// File: rtl/rsync_detector.sv
module rsync_detector
  import rsync_pkg::*;
#(
  parameter int OVERSAMPLE   = 16,
  parameter int STABLE_EDGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rxLine,
  input  logic mode16,
  input  logic rearm,
  output logic sampleStrobe,
  output logic sampleBit,
  output logic startDet
);

  ctrlStrobes_t ctrl;
  logic         flip;
  logic         filtLevel;

  rsync_control #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mode16   (mode16),
    .rearm    (rearm),
    .flip     (flip),
    .filtLevel(filtLevel),
    .ctrl     (ctrl),
    .startDet (startDet)
  );

  rsync_datapath #(.STABLE_EDGES(STABLE_EDGES)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .rxLine      (rxLine),
    .mode16      (mode16),
    .ctrl        (ctrl),
    .flip        (flip),
    .filtLevel   (filtLevel),
    .sampleStrobe(sampleStrobe),
    .sampleBit   (sampleBit)
  );

  // R9: outputs idle on the first cycle after reset
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sampleStrobe && !startDet));

endmodule

// File: tb/tb_rsync_detector.sv
`timescale 1ns/1ps
module tb_rsync_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxLine = 1'b1;
  logic mode16 = 1'b1;
  logic rearm = 1'b0;
  logic sampleStrobe, sampleBit, startDet;

  rsync_detector dut (
    .clk(clk), .rst(rst), .rxLine(rxLine), .mode16(mode16), .rearm(rearm),
    .sampleStrobe(sampleStrobe), .sampleBit(sampleBit), .startDet(startDet)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;
  int capN = 0;
  int capCyc [64];
  int capBit [64];
  int startN = 0;
  int startCyc = 0;

  // Monitor: record strobes away from the active edge
  always @(negedge clk) begin
    if (sampleStrobe && capN < 64) begin
      capBit[capN] = int'(sampleBit);
      capCyc[capN] = cyc;
      capN = capN + 1;
    end
    if (startDet) begin
      startN = startN + 1;
      startCyc = cyc;
    end
  end

  localparam logic [7:0] FRAMES [6] = '{8'h55, 8'h00, 8'hFF, 8'hA3, 8'h0F, 8'h96};

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic holdLine(input logic v, input int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic clearMon();
    capN = 0;
    startN = 0;
    startCyc = 0;
  endtask

  task automatic pulseRearm();
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] data);
    int e0;
    int bad;
    int got;
    clearMon();
    e0 = cyc + 1;
    holdLine(1'b0, 16);
    for (int i = 0; i < 8; i++) holdLine(data[i], 16);
    holdLine(1'b1, 16);
    pulseRearm();
    holdLine(1'b1, 8);
    chk("R2", "start pulses", startN, 1);
    chk("R2", "start cycle", startCyc, e0 + 10);
    chk("R5", "strobe count", capN, 9);
    bad = 0;
    got = 0;
    for (int k = 0; k < 9; k++) begin
      if (capCyc[k] != e0 + 10 + 16 * (k + 1)) bad++;
      if (k < 8) got = got | (capBit[k] << k);
    end
    chk("R5", "strobe timing errors", bad, 0);
    chk("R5", "received byte", got, int'(data));
    chk("R5", "stop bit", capBit[8], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int e0;
    int bad;
    // Reset state (R9)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "strobe after reset", int'(sampleStrobe), 0);
    chk("R9", "start after reset", int'(startDet), 0);
    chk("R9", "level after reset", int'(sampleBit), 1);
    holdLine(1'b1, 4);

    // Table of characters
    for (int f = 0; f < 6; f++) sendFrame(FRAMES[f]);

    // R1: short glitches leave everything idle
    clearMon();
    holdLine(1'b0, 2);
    holdLine(1'b1, 1);
    holdLine(1'b0, 2);
    holdLine(1'b1, 30);
    chk("R1", "start after glitches", startN, 0);
    chk("R4", "strobes after glitches", capN, 0);
    chk("R1", "level after glitches", int'(sampleBit), 1);

    // R3: eight-clock low is rejected
    clearMon();
    holdLine(1'b0, 8);
    holdLine(1'b1, 30);
    chk("R3", "start on 8-clock low", startN, 0);
    chk("R4", "strobes on 8-clock low", capN, 0);

    // R3 boundary: nine-clock low is accepted
    clearMon();
    e0 = cyc + 1;
    holdLine(1'b0, 9);
    holdLine(1'b1, 20);
    chk("R3", "start on 9-clock low", startN, 1);
    chk("R2", "start cycle on 9-clock low", startCyc, e0 + 10);
    pulseRearm();
    holdLine(1'b1, 8);

    // R6: stretched bit, later edge pulls the phase
    clearMon();
    e0 = cyc + 1;
    holdLine(1'b0, 16);
    holdLine(1'b1, 20);
    holdLine(1'b0, 16);
    pulseRearm();
    holdLine(1'b1, 10);
    chk("R6", "resync strobe count", capN, 2);
    chk("R6", "first strobe cycle", capCyc[0], e0 + 26);
    chk("R6", "first strobe bit", capBit[0], 1);
    chk("R6", "resynced strobe cycle", capCyc[1], e0 + 46);
    chk("R6", "resynced strobe bit", capBit[1], 0);

    // R7: change inside blanking interval is delayed
    clearMon();
    e0 = cyc + 1;
    holdLine(1'b0, 16);
    holdLine(1'b1, 3);
    holdLine(1'b0, 20);
    pulseRearm();
    holdLine(1'b1, 10);
    chk("R7", "blanked strobe count", capN, 1);
    chk("R7", "blanked strobe cycle", capCyc[0], e0 + 33);
    chk("R7", "blanked strobe bit", capBit[0], 0);

    // R9: reset in the middle of a character
    clearMon();
    holdLine(1'b0, 16);
    holdLine(1'b1, 12);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    clearMon();
    holdLine(1'b1, 30);
    chk("R9", "strobes after mid reset", capN, 0);
    chk("R9", "level after mid reset", int'(sampleBit), 1);

    // R9: rearm mid-character stops strobes
    clearMon();
    holdLine(1'b0, 16);
    holdLine(1'b0, 4);
    pulseRearm();
    clearMon();
    holdLine(1'b0, 40);
    chk("R9", "strobes after rearm", capN, 0);
    holdLine(1'b1, 10);

    // R8: direct 1x path
    rst = 1'b1;
    mode16 = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    clearMon();
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      logic v;
      v = (i >= 10 && i < 24) ? 1'b0 : logic'((i * 7) % 3 == 0);
      rxLine = v;
      @(negedge clk);
      if (!sampleStrobe || sampleBit != v) bad++;
    end
    chk("R8", "1x sample errors", bad, 0);
    chk("R8", "1x start pulses", startN, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule